// File: doc/BRIEF.md
# Low-Power Memory Read Strobe Shaper

This block sits between a bus cycle sequencer and an external memory. It drives the active-low memory select, output enable and write enable, and an I/O strobe. It also produces a one-period latch enable that tells the read data path when to capture. When the system runs slowly, a memory whose select and output enable stay low for a whole read cycle draws static current for that whole time. The shaper narrows the read window in one of two ways, which cuts that current.

The block is clocked by the fast, undivided reference clock. The sequencer gives a one-period `cyc_start` pulse in the period before a bus cycle begins, and a `cyc_last` pulse in the period before the final period of that cycle. In tail mode, the select and output enable are driven low only in the final period of a memory read. Tail mode is allowed only when the main oscillator is the source and its divider is 4, 6 or 8. In timed mode, the select and output enable are driven low as a pulse of a programmed number of reference periods from the start of the read. Timed mode is allowed only when the slow 32.768 kHz source is in use. In every other case, and for every write and I/O cycle, the strobes cover the whole bus cycle.

Top module: `lpcs_shaper`

## Requirements
- R1: While reset is asserted, and in the first period after it, `mem_cs_n`, `mem_oe_n`, `mem_we_n` and `io_stb_n` are 1 and `rd_latch` is 0.
- R2: A memory read (`cyc_kind` = 2'b00) in full mode drives `mem_cs_n` and `mem_oe_n` low in every period of the bus cycle. `rd_latch` is 1 only in the final period.
- R3: Tail mode is chosen only when `tail_en`=1, `src_slow`=0 and `main_div` is 3'd2, 3'd3 or 3'd4 (divide by 4, 6 or 8). With any other divider code, or with the slow source, the read uses full mode.
- R4: A tail-mode read drives `mem_cs_n` and `mem_oe_n` low only in the final period of the bus cycle, with `rd_latch` high in that same period.
- R5: Timed mode is chosen only when `timed_en`=1, `src_slow`=1 and `slow_div` is 3'd0 to 3'd4 (divide by 1, 2, 4, 8, 16). With any other code, or with the main source, the read uses full mode.
- R6: A timed-mode read drives `mem_cs_n` and `mem_oe_n` low in the first P periods of the bus cycle, where P = max(`pulse_len`, 1). The pulse ends early at the final period if the cycle is shorter. `rd_latch` is high in the last low period only, and the select is high in the period that follows it.
- R7: A memory write (`cyc_kind` = 2'b01) drives `mem_cs_n` and `mem_we_n` low in every period of the cycle, with `mem_oe_n` high and `rd_latch` 0, whatever the mode enables are.
- R8: An I/O cycle (`cyc_kind` = 2'b10 or 2'b11) drives `io_stb_n` low in every period of the cycle and keeps all memory strobes high and `rd_latch` 0, in every mode.
- R9: The mode, the enables and `pulse_len` are sampled only with `cyc_start`. Changes to them during a cycle have no effect on that cycle's strobes.
- R10: A new cycle may be started in the final period of the previous one. The new cycle's strobes then follow in the next period with no idle period between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Bus cycle begins in the next period |
| cyc_last | input | 1 | Next period is the final period of the cycle |
| cyc_kind | input | 2 | 00 mem read, 01 mem write, 10 I/O read, 11 I/O write |
| tail_en | input | 1 | Request tail-mode reads |
| timed_en | input | 1 | Request timed-pulse reads |
| src_slow | input | 1 | 1 when the 32.768 kHz source drives the system clock |
| main_div | input | 3 | Main divider code: 0 /1, 1 /2, 2 /4, 3 /6, 4 /8, others reserved |
| slow_div | input | 3 | Slow divider code: 0..4 for /1 to /16, others reserved |
| pulse_len | input | PLEN_W | Timed pulse width in reference periods (0 acts as 1) |
| mem_cs_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| io_stb_n | output | 1 | I/O cycle strobe, active low |
| rd_latch | output | 1 | Read data capture enable, active high |

## Verification
Two events can fall in the same period: the end of a timed pulse (the latch enable followed by release of the select) and the end of the bus cycle. The same holds for the final period of one cycle and the start of the next. The bench provokes the first with pulse widths equal to, longer than, and shorter than the cycle length. It provokes the second by issuing reads, writes and I/O cycles back to back with no idle period. Each period is judged against a per-period expected strobe vector computed from the rules above, so a latch enable that fires twice or a select that stays low one period too long is caught.

// File: rtl/lpcs_pkg.sv
package lpcs_pkg;
    typedef enum logic [1:0] {
        K_MRD  = 2'b00,
        K_MWR  = 2'b01,
        K_IORD = 2'b10,
        K_IOWR = 2'b11
    } cyc_kind_e;

    typedef enum logic [1:0] {
        M_FULL  = 2'd0,
        M_TAIL  = 2'd1,
        M_TIMED = 2'd2
    } rd_mode_e;

    localparam logic [2:0] MDIV_4   = 3'd2;
    localparam logic [2:0] MDIV_6   = 3'd3;
    localparam logic [2:0] MDIV_8   = 3'd4;
    localparam logic [2:0] SDIV_MAX = 3'd4;
endpackage

// File: rtl/lpcs_mode_sel.sv
module lpcs_mode_sel
    import lpcs_pkg::*;
(
    input  cyc_kind_e  kind,
    input  logic       tail_en,
    input  logic       timed_en,
    input  logic       src_slow,
    input  logic [2:0] main_div,
    input  logic [2:0] slow_div,
    output rd_mode_e   mode
);
    logic tail_ok;
    logic timed_ok;

    always_comb begin
        tail_ok  = tail_en && !src_slow &&
                   (main_div == MDIV_4 || main_div == MDIV_6 || main_div == MDIV_8);
        timed_ok = timed_en && src_slow && (slow_div <= SDIV_MAX);
        if (kind != K_MRD) begin
            mode = M_FULL;
        end else if (tail_ok) begin
            mode = M_TAIL;
        end else if (timed_ok) begin
            mode = M_TIMED;
        end else begin
            mode = M_FULL;
        end
    end
endmodule

// File: rtl/lpcs_pulse_timer.sv
module lpcs_pulse_timer #(
    parameter int PLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic [PLEN_W-1:0] plen_in,
    output logic              done_nx,
    output logic              end_nx
);
    localparam logic [PLEN_W-1:0] CNT_MAX = {PLEN_W{1'b1}};
    localparam logic [PLEN_W-1:0] ONE     = {{(PLEN_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [PLEN_W-1:0] cnt;
        logic [PLEN_W-1:0] plen;
        logic              done;
    } tmr_t;

    tmr_t tm_d, tm_q;

    always_comb begin
        tm_d = tm_q;
        if (start) begin
            tm_d.cnt  = ONE;
            tm_d.plen = (plen_in == '0) ? ONE : plen_in;
            tm_d.done = 1'b0;
        end else if (step) begin
            tm_d.done = tm_q.done || (tm_q.cnt >= tm_q.plen);
            if (tm_q.cnt != CNT_MAX) begin
                tm_d.cnt = tm_q.cnt + ONE;
            end
        end
        done_nx = tm_d.done;
        end_nx  = (tm_d.cnt >= tm_d.plen);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '{cnt: '0, plen: ONE, done: 1'b1};
        end else begin
            tm_q <= tm_d;
        end
    end

    assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tm_q.done && !start) |=> tm_q.done);
endmodule

// File: rtl/lpcs_shaper.sv
module lpcs_shaper
    import lpcs_pkg::*;
#(
    parameter int PLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              cyc_last,
    input  logic [1:0]        cyc_kind,
    input  logic              tail_en,
    input  logic              timed_en,
    input  logic              src_slow,
    input  logic [2:0]        main_div,
    input  logic [2:0]        slow_div,
    input  logic [PLEN_W-1:0] pulse_len,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              io_stb_n,
    output logic              rd_latch
);
    typedef struct packed {
        logic      active;
        logic      last;
        cyc_kind_e kind;
        rd_mode_e  mode;
        logic      cs_n;
        logic      oe_n;
        logic      we_n;
        logic      io_n;
        logic      dle;
    } st_t;

    localparam st_t ST_IDLE = '{active: 1'b0, last: 1'b0, kind: K_MRD, mode: M_FULL,
                               cs_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, io_n: 1'b1, dle: 1'b0};

    st_t      st_d, st_q;
    rd_mode_e mode_pick;
    logic     tmr_step;
    logic     tmr_done_nx;
    logic     tmr_end_nx;
    logic     rd_nx;
    logic     win_nx;

    lpcs_mode_sel u_mode (
        .kind     (cyc_kind_e'(cyc_kind)),
        .tail_en  (tail_en),
        .timed_en (timed_en),
        .src_slow (src_slow),
        .main_div (main_div),
        .slow_div (slow_div),
        .mode     (mode_pick)
    );

    assign tmr_step = st_q.active && !st_q.last && !cyc_start;

    lpcs_pulse_timer #(.PLEN_W(PLEN_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cyc_start),
        .step    (tmr_step),
        .plen_in (pulse_len),
        .done_nx (tmr_done_nx),
        .end_nx  (tmr_end_nx)
    );

    always_comb begin
        st_d = st_q;
        if (cyc_start) begin
            st_d.active = 1'b1;
            st_d.kind   = cyc_kind_e'(cyc_kind);
            st_d.mode   = mode_pick;
            st_d.last   = cyc_last;
        end else if (st_q.active && !st_q.last) begin
            st_d.last   = cyc_last;
        end else begin
            st_d.active = 1'b0;
            st_d.last   = 1'b0;
        end

        rd_nx = st_d.active && (st_d.kind == K_MRD);
        unique case (st_d.mode)
            M_TAIL:  win_nx = st_d.last;
            M_TIMED: win_nx = !tmr_done_nx;
            default: win_nx = 1'b1;
        endcase

        st_d.we_n = !(st_d.active && st_d.kind == K_MWR);
        st_d.io_n = !(st_d.active && (st_d.kind == K_IORD || st_d.kind == K_IOWR));
        st_d.oe_n = !(rd_nx && win_nx);
        st_d.cs_n = st_d.oe_n && st_d.we_n;
        if (st_d.mode == M_TIMED) begin
            st_d.dle = rd_nx && win_nx && (tmr_end_nx || st_d.last);
        end else begin
            st_d.dle = rd_nx && st_d.last;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_cs_n = st_q.cs_n;
    assign mem_oe_n = st_q.oe_n;
    assign mem_we_n = st_q.we_n;
    assign io_stb_n = st_q.io_n;
    assign rd_latch = st_q.dle;

    assert_write_no_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n && !rd_latch));

    assert_io_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !io_stb_n |-> (mem_cs_n && mem_oe_n && mem_we_n && !rd_latch));

    assert_latch_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_latch |-> (!mem_cs_n && !mem_oe_n));

    assert_tail_final_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.mode == M_TAIL && !mem_oe_n) |-> $past(cyc_last));

    assert_timed_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_latch && st_q.mode == M_TIMED && !cyc_start) |=> mem_cs_n);
endmodule

// File: tb/tb_lpcs_shaper.sv
module tb_lpcs_shaper;
    localparam int CLK_PERIOD = 10;
    localparam int PLEN_W     = 8;
    localparam logic [4:0] IDLE_V = 5'b11110; // {cs_n, oe_n, we_n, io_n, rd_latch}

    typedef struct {
        logic [4:0] exp;
        string      req;
    } item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cyc_start = 1'b0;
    logic              cyc_last = 1'b0;
    logic [1:0]        cyc_kind = 2'b00;
    logic              tail_en = 1'b0;
    logic              timed_en = 1'b0;
    logic              src_slow = 1'b0;
    logic [2:0]        main_div = 3'd0;
    logic [2:0]        slow_div = 3'd0;
    logic [PLEN_W-1:0] pulse_len = '0;
    logic              mem_cs_n, mem_oe_n, mem_we_n, io_stb_n, rd_latch;

    int    n_vec  = 0;
    int    n_fail = 0;
    item_t sb[$];

    lpcs_shaper #(.PLEN_W(PLEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_last(cyc_last),
        .cyc_kind(cyc_kind), .tail_en(tail_en), .timed_en(timed_en),
        .src_slow(src_slow), .main_div(main_div), .slow_div(slow_div),
        .pulse_len(pulse_len), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .io_stb_n(io_stb_n), .rd_latch(rd_latch)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [4:0] outs();
        return {mem_cs_n, mem_oe_n, mem_we_n, io_stb_n, rd_latch};
    endfunction

    // 0 full, 1 tail, 2 timed: from R3 and R5
    function automatic int pick_mode(input logic [1:0] kind);
        if (kind != 2'b00) return 0;
        if (tail_en && !src_slow && (main_div >= 3'd2 && main_div <= 3'd4)) return 1;
        if (timed_en && src_slow && slow_div <= 3'd4) return 2;
        return 0;
    endfunction

    task automatic check(input logic [4:0] exp, input string req);
        n_vec++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, outs(), exp, $time);
        end
    endtask

    // monitor: pops one expected vector per period
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(it.exp, it.req);
            end
        end
    end

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc_start = 1'b0;
            cyc_last  = 1'b0;
            @(posedge clk);
            sb.push_back('{IDLE_V, req});
        end
    endtask

    task automatic bus_cycle(input logic [1:0] kind, input int len,
                             input bit disturb, input string req);
        int  m;
        int  pe;
        m  = pick_mode(kind);
        pe = (pulse_len == 0) ? 1 : int'(pulse_len);
        for (int i = 0; i < len; i++) begin
            logic [4:0] e;
            bit         lst;
            bit         win;
            @(negedge clk);
            cyc_start = (i == 0);
            cyc_last  = (i == len - 1);
            cyc_kind  = kind;
            if (disturb && i == 1) begin
                tail_en   = !tail_en;
                timed_en  = !timed_en;
                pulse_len = pulse_len + 8'd5;
            end
            @(posedge clk);
            lst = (i == len - 1);
            case (kind)
                2'b01:   e = 5'b01010;
                2'b10,
                2'b11:   e = 5'b11100;
                default: begin
                    if (m == 1)      win = lst;
                    else if (m == 2) win = (i < pe);
                    else             win = 1'b1;
                    e[4:1] = win ? 4'b0011 : 4'b1111;
                    e[0]   = (m == 2) ? (win && (i == pe - 1 || lst)) : lst;
                end
            endcase
            sb.push_back('{e, req});
        end
    endtask

    task automatic cfg(input bit te, input bit me, input bit slow,
                       input logic [2:0] md, input logic [2:0] sd, input int pl);
        tail_en = te; timed_en = me; src_slow = slow;
        main_div = md; slow_div = sd; pulse_len = PLEN_W'(pl);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(IDLE_V, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(IDLE_V, "R1 after reset");

        cfg(0, 0, 0, 3'd0, 3'd0, 0);
        bus_cycle(2'b00, 4, 0, "R2 full read");
        idle(1, "R2 idle");
        bus_cycle(2'b00, 1, 0, "R2 full read len1");
        idle(1, "R2 idle");

        cfg(1, 0, 0, 3'd2, 3'd0, 0);
        bus_cycle(2'b00, 4, 0, "R4 tail /4");
        idle(1, "R4 idle");
        cfg(1, 0, 0, 3'd3, 3'd0, 0);
        bus_cycle(2'b00, 3, 0, "R3 tail /6");
        cfg(1, 0, 0, 3'd4, 3'd0, 0);
        bus_cycle(2'b00, 3, 0, "R3 tail /8");
        idle(1, "R3 idle");
        cfg(1, 0, 0, 3'd1, 3'd0, 0);
        bus_cycle(2'b00, 3, 0, "R3 tail refused /2");
        cfg(1, 0, 0, 3'd5, 3'd0, 0);
        bus_cycle(2'b00, 3, 0, "R3 tail refused reserved");
        cfg(1, 0, 1, 3'd2, 3'd0, 0);
        bus_cycle(2'b00, 3, 0, "R3 tail refused slow src");
        idle(1, "R3 idle");

        cfg(0, 1, 1, 3'd0, 3'd0, 3);
        bus_cycle(2'b00, 6, 0, "R6 timed pulse 3");
        idle(1, "R6 idle");
        cfg(0, 1, 1, 3'd0, 3'd4, 1);
        bus_cycle(2'b00, 3, 0, "R5 timed /16");
        cfg(0, 1, 1, 3'd0, 3'd5, 2);
        bus_cycle(2'b00, 3, 0, "R5 timed refused reserved");
        cfg(0, 1, 0, 3'd2, 3'd0, 2);
        bus_cycle(2'b00, 3, 0, "R5 timed refused main src");
        cfg(0, 1, 1, 3'd0, 3'd2, 8);
        bus_cycle(2'b00, 4, 0, "R6 timed truncated");
        cfg(0, 1, 1, 3'd0, 3'd2, 4);
        bus_cycle(2'b00, 4, 0, "R6 timed equal len");
        cfg(0, 1, 1, 3'd0, 3'd1, 0);
        bus_cycle(2'b00, 3, 0, "R6 timed zero len");
        idle(1, "R6 idle");

        cfg(1, 0, 0, 3'd2, 3'd0, 0);
        bus_cycle(2'b01, 3, 0, "R7 write tail cfg");
        cfg(0, 1, 1, 3'd0, 3'd0, 1);
        bus_cycle(2'b01, 2, 0, "R7 write timed cfg");
        idle(1, "R7 idle");

        cfg(1, 0, 0, 3'd3, 3'd0, 0);
        bus_cycle(2'b10, 3, 0, "R8 io read tail cfg");
        cfg(0, 1, 1, 3'd0, 3'd0, 1);
        bus_cycle(2'b11, 3, 0, "R8 io write timed cfg");
        idle(1, "R8 idle");

        cfg(0, 1, 1, 3'd0, 3'd0, 2);
        bus_cycle(2'b00, 5, 1, "R9 timed disturbed");
        idle(1, "R9 idle");
        cfg(1, 0, 0, 3'd4, 3'd0, 0);
        bus_cycle(2'b00, 4, 1, "R9 tail disturbed");
        idle(1, "R9 idle");

        cfg(0, 1, 1, 3'd0, 3'd0, 1);
        bus_cycle(2'b00, 3, 0, "R10 b2b timed");
        bus_cycle(2'b00, 2, 0, "R10 b2b timed second");
        bus_cycle(2'b01, 2, 0, "R10 b2b write");
        cfg(1, 0, 0, 3'd2, 3'd0, 0);
        bus_cycle(2'b00, 1, 0, "R10 b2b tail len1");
        bus_cycle(2'b10, 2, 0, "R10 b2b io");
        bus_cycle(2'b00, 2, 0, "R10 b2b tail");
        idle(2, "R10 idle");

        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got hang expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule